// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block is a slave parallel port. An external host and a processor core exchange data through it. The host writes words into an input register and reads words from an output register. Two flags govern the exchange. The input-full flag is set by a completed host write and cleared when the core reads the input register. The output-empty flag is cleared when the core loads the output register and set again when the host has read the whole word.

A 7-bit configuration word changes the port's behaviour at run time. It selects:
- 8-bit or 16-bit transfers;
- one of two host bus protocols: separate write and read strobes (both active-low), or a direction line plus one data strobe whose polarity is programmable;
- how the byte-select pin maps to the halves of the data register;
- the polarity of the two flag pins, and whether the empty flag is merged onto the full-flag pin;
- the sense of the empty flag as the core reads it.

The host strobes pass through a synchronizer. A transfer is committed when the strobe is released. A small state machine handles this, with four states:
- HOLDOFF waits for the strobes to be idle. The port enters it from reset and after every configuration write.
- IDLE waits for a strobe to be asserted, which moves it to ACTIVE.
- ACTIVE holds the direction latched at assertion. Releasing the strobe moves it to COMMIT.
- COMMIT lasts one cycle and applies the transfer's effect on the registers and flags, then returns to IDLE.

A configuration write moves the machine from any state to HOLDOFF. HOLDOFF moves to IDLE once the strobe is inactive.

Top module: `par_host_port`

## Requirements
- R1: After reset the configuration reads 0, the input register reads 0, input-full is clear and output-empty is set. With the default configuration, `host_ibf_pin` is 0, `host_obe_pin` is 1 and `core_stat` is 2'b10 (bit 1 is output-empty status, bit 0 is input-full).
- R2: In 16-bit mode a completed host write loads the input register and sets input-full. A `core_in_re` pulse clears input-full.
- R3: In 8-bit mode (config bit 0 = 0), host data moves on `host_din[7:0]` and `host_dout[7:0]`, and `host_dout[15:8]` reads 0. A host write to the low byte leaves input-full clear, and a write to the high byte sets it. A host read of the low byte leaves output-empty clear, and a read of the high byte sets it.
- R4: The low half is selected when `host_bsel` equals config bit 3. In 8-bit mode the other value selects the high byte. In 16-bit mode the other value swaps the two bus halves, for both writes and reads.
- R5: A core write to the output register clears output-empty. A completed host read of the full word sets it. While a read strobe is asserted, `host_dout` shows the output register as mapped by R4.
- R6: With config bit 1 = 0, `host_stb_a` is an active-low write strobe and `host_stb_b` is an active-low read strobe. With bit 1 = 1, `host_stb_b` is the direction line (1 = read) and `host_stb_a` is the data strobe, which is active-low when config bit 2 is 0 and active-high when it is 1.
- R7: Config bit 4 = 0 makes both flag pins active-high, and bit 4 = 1 makes them active-low.
- R8: With config bit 5 = 1, `host_ibf_pin` carries input-full OR output-empty, before the polarity of R7 is applied, and `host_obe_pin` is unaffected.
- R9: With config bit 6 = 1, output-empty reads inverted in `core_stat[1]`; with bit 6 = 0 it reads true. `core_stat[0]` always shows input-full.
- R10: A transfer takes effect only after its strobe is released. Holding the strobe asserted changes no flag.
- R11: Configuration bits 15..7 read back as 0.
- R12: A configuration write made while a strobe is asserted abandons that access. Releasing the strobe commits nothing, and the next complete access works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_cfg_we | input | 1 | Configuration write enable |
| core_cfg_wdata | input | 7 | Configuration write value |
| core_cfg_rdata | output | 16 | Configuration readback, bits 15..7 zero |
| core_out_we | input | 1 | Core write to the output register |
| core_out_wdata | input | 16 | Output register write value |
| core_in_re | input | 1 | Core read of the input register, clears input-full |
| core_in_rdata | output | 16 | Input register contents |
| core_stat | output | 2 | {output-empty status, input-full} |
| host_stb_a | input | 1 | Write strobe, or data strobe |
| host_stb_b | input | 1 | Read strobe, or direction line |
| host_bsel | input | 1 | Byte select |
| host_din | input | 16 | Host write data |
| host_dout | output | 16 | Host read data |
| host_ibf_pin | output | 1 | Input-full pin (possibly merged) |
| host_obe_pin | output | 1 | Output-empty pin |

## Verification
A wrong state in the strobe machine shows up in the flags. A lost or duplicated commit sets or misses input-full or output-empty. That change reaches `core_stat` and the flag pins about four cycles after the strobe is released: two synchronizer stages, the move to COMMIT and the register update. A wrong byte-select decode or assembly appears at once in `core_in_rdata` after the commit, or on `host_dout` while the read strobe is held. The bench therefore checks every protocol, polarity, sense and byte-select combination through a full write and read round trip. It then walks all four flag states against all eight flag-pin and status settings.

// File: rtl/hostport_pkg.sv
package hostport_pkg;

    typedef struct packed {
        logic stat_inv;
        logic flag_merge;
        logic flag_inv;
        logic bsel_inv;
        logic stb_pol;
        logic proto;
        logic wide;
    } hp_cfg_t;

    localparam int CFG_W = $bits(hp_cfg_t);

    typedef enum logic [1:0] {
        HP_HOLDOFF,
        HP_IDLE,
        HP_ACTIVE,
        HP_COMMIT
    } hp_state_t;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (STAGES < 2) begin : g_single
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= RST_VAL;
                else        stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hp_fsm.sv
module hp_fsm
    import hostport_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      proto,
    input  logic      stb_pol,
    input  logic      sa,
    input  logic      sb,
    input  logic      restart,
    output hp_state_t state_o,
    output logic      wr_done,
    output logic      rd_done
);
    hp_state_t st, st_nxt;
    logic      dir_q;
    logic      act, is_rd;

    // strobe decode for the selected protocol
    always_comb begin
        if (proto) begin
            act   = stb_pol ? sa : !sa;
            is_rd = sb;
        end else begin
            act   = !sa || !sb;
            is_rd = !sb;
        end
    end

    always_comb begin
        st_nxt = st;
        if (restart) begin
            st_nxt = HP_HOLDOFF;
        end else begin
            unique case (st)
                HP_HOLDOFF: if (!act) st_nxt = HP_IDLE;
                HP_IDLE:    if (act)  st_nxt = HP_ACTIVE;
                HP_ACTIVE:  if (!act) st_nxt = HP_COMMIT;
                HP_COMMIT:            st_nxt = HP_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= HP_HOLDOFF;
            dir_q <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st == HP_IDLE && act) dir_q <= is_rd;
        end
    end

    // outputs
    always_comb begin
        state_o = st;
        wr_done = (st == HP_COMMIT) && !dir_q;
        rd_done = (st == HP_COMMIT) && dir_q;
    end
endmodule

// File: rtl/hp_regs.sv
module hp_regs #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wide,
    input  logic          low_sel,
    input  logic          wr_done,
    input  logic          rd_done,
    input  logic [DW-1:0] host_din,
    input  logic          core_in_re,
    input  logic          core_out_we,
    input  logic [DW-1:0] core_out_wdata,
    output logic [DW-1:0] in_reg,
    output logic [DW-1:0] out_reg,
    output logic          ibf,
    output logic          obe
);
    localparam int H = DW / 2;

    logic full_rd;
    assign full_rd = rd_done && (wide || !low_sel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_reg <= '0;
            ibf    <= 1'b0;
        end else begin
            if (wr_done) begin
                if (wide)
                    in_reg <= low_sel ? host_din : {host_din[H-1:0], host_din[DW-1:H]};
                else if (low_sel)
                    in_reg[H-1:0] <= host_din[H-1:0];
                else
                    in_reg[DW-1:H] <= host_din[H-1:0];
            end
            if (wr_done && (wide || !low_sel)) ibf <= 1'b1;
            else if (core_in_re)               ibf <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_reg <= '0;
            obe     <= 1'b1;
        end else begin
            if (core_out_we) out_reg <= core_out_wdata;
            if (full_rd)          obe <= 1'b1;
            else if (core_out_we) obe <= 1'b0;
        end
    end
endmodule

// File: rtl/par_host_port.sv
module par_host_port
    import hostport_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_cfg_we,
    input  logic [CFG_W-1:0] core_cfg_wdata,
    output logic [DW-1:0]    core_cfg_rdata,
    input  logic             core_out_we,
    input  logic [DW-1:0]    core_out_wdata,
    input  logic             core_in_re,
    output logic [DW-1:0]    core_in_rdata,
    output logic [1:0]       core_stat,
    input  logic             host_stb_a,
    input  logic             host_stb_b,
    input  logic             host_bsel,
    input  logic [DW-1:0]    host_din,
    output logic [DW-1:0]    host_dout,
    output logic             host_ibf_pin,
    output logic             host_obe_pin
);
    localparam int H = DW / 2;

    hp_cfg_t   cfg_q;
    logic [1:0] stb_s;
    hp_state_t st;
    logic      wr_done, rd_done;
    logic      low_sel;
    logic      ibf_q, obe_q;
    logic [DW-1:0] in_reg, out_reg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cfg_q <= '0;
        else if (core_cfg_we) cfg_q <= hp_cfg_t'(core_cfg_wdata);
    end

    assign core_cfg_rdata = {{(DW-CFG_W){1'b0}}, cfg_q};
    assign low_sel        = (host_bsel == cfg_q.bsel_inv);

    hp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_stb_b, host_stb_a}),
        .q     (stb_s)
    );

    hp_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .proto   (cfg_q.proto),
        .stb_pol (cfg_q.stb_pol),
        .sa      (stb_s[0]),
        .sb      (stb_s[1]),
        .restart (core_cfg_we),
        .state_o (st),
        .wr_done (wr_done),
        .rd_done (rd_done)
    );

    hp_regs #(.DW(DW)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wide           (cfg_q.wide),
        .low_sel        (low_sel),
        .wr_done        (wr_done),
        .rd_done        (rd_done),
        .host_din       (host_din),
        .core_in_re     (core_in_re),
        .core_out_we    (core_out_we),
        .core_out_wdata (core_out_wdata),
        .in_reg         (in_reg),
        .out_reg        (out_reg),
        .ibf            (ibf_q),
        .obe            (obe_q)
    );

    always_comb begin
        core_in_rdata = in_reg;
        core_stat     = {obe_q ^ cfg_q.stat_inv, ibf_q};
        host_ibf_pin  = (ibf_q | (cfg_q.flag_merge & obe_q)) ^ cfg_q.flag_inv;
        host_obe_pin  = obe_q ^ cfg_q.flag_inv;
        if (cfg_q.wide)
            host_dout = low_sel ? out_reg : {out_reg[H-1:0], out_reg[DW-1:H]};
        else
            host_dout = {{(DW-H){1'b0}}, (low_sel ? out_reg[H-1:0] : out_reg[DW-1:H])};
    end
endmodule

// File: rtl/hp_checker.sv
module hp_checker
    import hostport_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input hp_state_t state,
    input logic      wr_done,
    input logic      rd_done,
    input logic      ibf,
    input logic      obe,
    input logic      core_in_re,
    input logic      core_out_we,
    input logic      core_cfg_we,
    input logic      merge,
    input logic      finv,
    input logic      ibf_pin,
    input logic      obe_pin
);
    assert_ibf_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_in_re && !wr_done |=> !ibf);

    assert_obe_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_out_we && !rd_done |=> !obe);

    assert_merge_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        merge && !finv && obe_pin |-> ibf_pin);

    assert_ibf_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ibf) |-> $past(wr_done));

    assert_commit_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        state == HP_COMMIT |-> $past(state) == HP_ACTIVE);

    assert_commit_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done || rd_done) |=> !(wr_done || rd_done));

    assert_holdoff_R12: assert property (@(posedge clk) disable iff (!rst_n)
        core_cfg_we |=> state == HP_HOLDOFF);
endmodule

bind par_host_port hp_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (st),
    .wr_done     (wr_done),
    .rd_done     (rd_done),
    .ibf         (ibf_q),
    .obe         (obe_q),
    .core_in_re  (core_in_re),
    .core_out_we (core_out_we),
    .core_cfg_we (core_cfg_we),
    .merge       (cfg_q.flag_merge),
    .finv        (cfg_q.flag_inv),
    .ibf_pin     (host_ibf_pin),
    .obe_pin     (host_obe_pin)
);

// File: tb/par_host_port_bench.sv
module par_host_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_cfg_we = 1'b0;
    logic [6:0]  core_cfg_wdata = '0;
    logic [15:0] core_cfg_rdata;
    logic        core_out_we = 1'b0;
    logic [15:0] core_out_wdata = '0;
    logic        core_in_re = 1'b0;
    logic [15:0] core_in_rdata;
    logic [1:0]  core_stat;
    logic        host_stb_a = 1'b1;
    logic        host_stb_b = 1'b1;
    logic        host_bsel = 1'b0;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic        host_ibf_pin, host_obe_pin;

    int n_chk = 0;
    int n_err = 0;
    logic [6:0] cur_cfg = '0;
    bit done = 0;

    always #4 clk = ~clk;

    par_host_port u_par_host_port (.*);

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic idle_pins(input logic [6:0] c);
        if (c[1]) begin host_stb_a = ~c[2]; host_stb_b = 1'b0; end
        else      begin host_stb_a = 1'b1;  host_stb_b = 1'b1; end
    endtask

    task automatic set_cfg(input logic [6:0] v);
        idle_pins(v);
        core_cfg_we = 1'b1; core_cfg_wdata = v;
        tick(1);
        core_cfg_we = 1'b0;
        cur_cfg = v;
        tick(4);
    endtask

    task automatic host_xfer(input logic rd, input logic bs, input logic [15:0] d,
                             output logic [15:0] q);
        host_bsel = bs; host_din = d;
        if (cur_cfg[1]) begin
            host_stb_b = rd; tick(1);
            host_stb_a = cur_cfg[2];
        end else if (rd) host_stb_b = 1'b0;
        else             host_stb_a = 1'b0;
        tick(4);
        q = host_dout;
        idle_pins(cur_cfg);
        tick(6);
    endtask

    task automatic core_rd();
        core_in_re = 1'b1; tick(1); core_in_re = 1'b0; tick(1);
    endtask

    task automatic core_wr(input logic [15:0] v);
        core_out_we = 1'b1; core_out_wdata = v; tick(1); core_out_we = 1'b0; tick(1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] q, d, e, expv;
        int idx;
        idx = 0;
        tick(3);
        rst_n = 1'b1;
        tick(4);
        // R1 reset state
        check("R1 cfg", core_cfg_rdata, 16'h0000);
        check("R1 in", core_in_rdata, 16'h0000);
        check("R1 stat", {14'b0, core_stat}, 16'h0002);
        check("R1 pins", {14'b0, host_ibf_pin, host_obe_pin}, 16'h0001);

        // R2 R4 R5 R6: 16-bit round trips over protocol, polarity, sense, bsel
        for (int p = 0; p < 2; p++)
            for (int pl = 0; pl <= p; pl++)
                for (int s = 0; s < 2; s++)
                    for (int b = 0; b < 2; b++) begin
                        set_cfg({3'b000, s[0], pl[0], p[0], 1'b1});
                        d = 16'h3C5A + 16'(idx) * 16'h0B17;
                        idx++;
                        host_xfer(1'b0, b[0], d, q);
                        expv = (b == s) ? d : {d[7:0], d[15:8]};
                        check("R4 R6 write data", core_in_rdata, expv);
                        check("R2 ibf set", {15'b0, core_stat[0]}, 16'h0001);
                        core_rd();
                        check("R2 ibf clear", {15'b0, core_stat[0]}, 16'h0000);
                        e = ~d;
                        core_wr(e);
                        check("R5 obe clear", {15'b0, core_stat[1]}, 16'h0000);
                        host_xfer(1'b1, b[0], 16'h0, q);
                        expv = (b == s) ? e : {e[7:0], e[15:8]};
                        check("R5 R4 read data", q, expv);
                        check("R5 obe set", {15'b0, core_stat[1]}, 16'h0001);
                    end

        // R3: 8-bit byte assembly and byte reads
        for (int s = 0; s < 2; s++) begin
            set_cfg({3'b000, s[0], 3'b000});
            d = 16'h91E4 ^ (16'(s) * 16'h4242);
            host_xfer(1'b0, s[0], {8'h00, d[7:0]}, q);
            check("R3 low write keeps ibf", {15'b0, core_stat[0]}, 16'h0000);
            host_xfer(1'b0, ~s[0], {8'h00, d[15:8]}, q);
            check("R3 high write sets ibf", {15'b0, core_stat[0]}, 16'h0001);
            check("R3 assembled", core_in_rdata, d);
            core_rd();
            e = d ^ 16'h5A5A;
            core_wr(e);
            host_xfer(1'b1, s[0], 16'h0, q);
            check("R3 low read data", q, {8'h00, e[7:0]});
            check("R3 low read keeps obe", {15'b0, core_stat[1]}, 16'h0000);
            host_xfer(1'b1, ~s[0], 16'h0, q);
            check("R3 high read data", q, {8'h00, e[15:8]});
            check("R3 high read sets obe", {15'b0, core_stat[1]}, 16'h0001);
        end

        // R7 R8 R9: every flag state against every pin/status setting
        set_cfg(7'h01);
        for (int k = 0; k < 4; k++) begin
            logic fi, fo;
            set_cfg(7'h01);
            if (k == 1) core_wr(16'h1234);
            if (k == 2) host_xfer(1'b0, 1'b0, 16'h4321, q);
            if (k == 3) host_xfer(1'b1, 1'b0, 16'h0, q);
            fi = (k >= 2);
            fo = (k == 0) || (k == 3);
            for (int f = 0; f < 8; f++) begin
                set_cfg({f[2:0], 4'b0001});
                check("R7 R8 ibf pin", {15'b0, host_ibf_pin}, {15'b0, (fi | (f[1] & fo)) ^ f[0]});
                check("R7 obe pin", {15'b0, host_obe_pin}, {15'b0, fo ^ f[0]});
                check("R9 status", {14'b0, core_stat}, {14'b0, fo ^ f[2], fi});
            end
        end

        // R10: held strobe commits nothing until release
        set_cfg(7'h01);
        core_rd();
        host_stb_a = 1'b0;
        tick(10);
        check("R10 held no ibf", {15'b0, core_stat[0]}, 16'h0000);
        host_stb_a = 1'b1;
        tick(6);
        check("R10 release sets ibf", {15'b0, core_stat[0]}, 16'h0001);
        core_rd();

        // R12: configuration write during an access abandons it
        host_din = 16'hBEEF;
        host_stb_a = 1'b0;
        tick(5);
        core_cfg_we = 1'b1; core_cfg_wdata = 7'h01; tick(1); core_cfg_we = 1'b0;
        tick(3);
        host_stb_a = 1'b1;
        tick(6);
        check("R12 abandoned", {15'b0, core_stat[0]}, 16'h0000);
        host_xfer(1'b0, 1'b0, 16'hCAFE, q);
        check("R12 next access", core_in_rdata, 16'hCAFE);

        // R11: reserved readback
        set_cfg(7'h7F);
        check("R11 reserved zero", core_cfg_rdata, 16'h007F);

        finish_run();
    end
endmodule